// File: doc/BRIEF.md
# Halved-Table Partial-Sum Generator for Distributed-Arithmetic Filters

This block produces the partial sum for one four-tap group of a bit-serial distributed-arithmetic FIR filter. In each bit period the filter presents one bit of each of the four samples in the group. The block returns the signed sum of the fixed coefficients whose bit is set. The coefficients are parameters, so all stored words are computed during elaboration. The result is purely combinational, and the scaling accumulator that weights successive bit periods sits outside the block.

The full sixteen-word table is not stored. The words for the lower address bits are held in a small table. Each remaining address bit is handled by a fold stage. A fold stage is a 2:1 multiplexer that picks zero or that bit's coefficient, followed by an adder. The parameter `LEVELS` sets how many of the top address bits are folded. The settings are:
- `LEVELS = 0`: a complete sixteen-word table.
- `LEVELS = 1`: an eight-word table plus one fold.
- `LEVELS = TAPS`: no table, only multiplexers and adders.

Every setting gives the same output for every address.

Top module: `dapsg_core`

## Requirements
- R1: For every 4-bit address, `psum_o` equals the signed sum of the coefficients whose address bits are 1. Address bit i selects coefficient i, and coefficient i sits in bits [i*12 +: 12] of `COEFS`.
- R2: With `LEVELS` = k (0 to 4), the block stores 2^(4-k) table words, folds the top k address bits, and still meets R1 for all sixteen addresses.
- R3: Address 0 gives `psum_o` = 0 for any coefficient set and any `LEVELS`.
- R4: An address with exactly one bit i set gives exactly coefficient i, sign-extended to the output width.
- R5: Coefficients are 12-bit two's complement. Negative values are sign-extended into the 14-bit output. All four at -2048 with address 15 gives -8192, and all four at 2047 with address 15 gives 8188.
- R6: `psum_o` never wraps. It always lies between the sum of the negative coefficients and the sum of the positive coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tap_bits_i | input | 4 | One bit from each of the four samples of the group; bit i belongs to tap i |
| psum_o | output | 14 | Signed sum of the coefficients selected by `tap_bits_i` |

## Verification
The block contains no register, so each result is due in the same clock period in which its address is applied. The driver changes the address just after a rising edge and records the expected sums in a queue. The monitor pops and compares them at the following falling edge, half a period later, when no driver activity is pending. Five instances run side by side. They cover table sizes of 16, 8, 4, 2 and 0 words, with mixed-sign, all-minimum and all-maximum coefficient sets. Every instance is swept through an ascending order and a Gray-code order of all sixteen addresses.

// File: rtl/dapsg_pkg.sv
package dapsg_pkg;

   // upper bound on group size accepted by the generator
   localparam int unsigned DA_MAX_TAPS = 8;

   // structural form picked from the fold count
   typedef enum logic [1:0] {
      FORM_FULL_TABLE,
      FORM_SPLIT,
      FORM_MUX_ONLY
   } da_form_e;

   // output width that holds the sum of `taps` signed words of `cw` bits
   function automatic int unsigned psum_width(int unsigned cw, int unsigned taps);
      return cw + $clog2(taps);
   endfunction

   function automatic da_form_e form_of(int unsigned levels, int unsigned taps);
      if (levels == 0)
         return FORM_FULL_TABLE;
      else if (levels >= taps)
         return FORM_MUX_ONLY;
      else
         return FORM_SPLIT;
   endfunction

endpackage

// File: rtl/dapsg_table.sv
// Constant word table over the low IDX_W address bits; words fixed at elaboration.
module dapsg_table #(
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned SUM_W  = 14,
   parameter logic [IDX_W*COEF_W-1:0] COEFS_LO = '0
) (
   input  logic [IDX_W-1:0]        idx_i,
   output logic signed [SUM_W-1:0] word_o
);

   localparam int unsigned DEPTH = 2 ** IDX_W;

   if (IDX_W < 1 || IDX_W > dapsg_pkg::DA_MAX_TAPS) begin : g_bad_idx
      $error("dapsg_table: IDX_W out of range");
   end

   function automatic logic signed [SUM_W-1:0] word_for(int unsigned idx);
      logic signed [SUM_W-1:0]  acc;
      logic signed [COEF_W-1:0] c;
      acc = '0;
      for (int j = 0; j < IDX_W; j++) begin
         c = COEFS_LO[j*COEF_W +: COEF_W];
         if (idx[j])
            acc = acc + SUM_W'(c);
      end
      return acc;
   endfunction

   logic signed [SUM_W-1:0] rom [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic signed [SUM_W-1:0] WORD = word_for(w);
      assign rom[w] = WORD;
   end

   assign word_o = rom[idx_i];

endmodule

// File: rtl/dapsg_fold.sv
// One fold stage: select zero or the stage coefficient, then add it to the incoming sum.
module dapsg_fold #(
   parameter int unsigned COEF_W = 12,
   parameter int unsigned SUM_W  = 14,
   parameter logic signed [COEF_W-1:0] COEF = '0
) (
   input  logic                    sel_i,
   input  logic signed [SUM_W-1:0] part_i,
   output logic signed [SUM_W-1:0] part_o
);

   if (SUM_W < COEF_W) begin : g_bad_w
      $error("dapsg_fold: SUM_W narrower than COEF_W");
   end

   localparam logic signed [SUM_W-1:0] COEF_EXT = SUM_W'(COEF);

   logic signed [SUM_W-1:0] addend;

   always_comb begin
      addend = sel_i ? COEF_EXT : '0;
      part_o = part_i + addend;
   end

endmodule

// File: rtl/dapsg_core.sv
// Partial-sum generator for one tap group: table over low bits, fold stages for the top LEVELS bits.
module dapsg_core
   import dapsg_pkg::*;
#(
   parameter int unsigned TAPS   = 4,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned LEVELS = 1,
   parameter logic [TAPS*COEF_W-1:0] COEFS =
      {12'sd55, -12'sd48, 12'sd30, -12'sd10}
) (
   input  logic [TAPS-1:0]                                     tap_bits_i,
   output logic signed [dapsg_pkg::psum_width(COEF_W,TAPS)-1:0] psum_o
);

   localparam int unsigned SUM_W = psum_width(COEF_W, TAPS);
   localparam int unsigned TBITS = TAPS - LEVELS;
   localparam da_form_e    FORM  = form_of(LEVELS, TAPS);

   if (TAPS < 1 || TAPS > DA_MAX_TAPS) begin : g_bad_taps
      $error("dapsg_core: TAPS out of range");
   end
   if (LEVELS > TAPS) begin : g_bad_levels
      $error("dapsg_core: LEVELS exceeds TAPS");
   end
   if (COEF_W < 2) begin : g_bad_cw
      $error("dapsg_core: COEF_W too small");
   end

   logic signed [SUM_W-1:0] base_sum;
   logic signed [SUM_W-1:0] chain [LEVELS+1];

   // base: stored words for the low address bits, or zero when nothing is stored
   if (FORM == FORM_MUX_ONLY) begin : g_no_table
      assign base_sum = '0;
   end else begin : g_table
      dapsg_table #(
         .IDX_W   (TBITS),
         .COEF_W  (COEF_W),
         .SUM_W   (SUM_W),
         .COEFS_LO(COEFS[TBITS*COEF_W-1:0])
      ) u_table (
         .idx_i (tap_bits_i[TBITS-1:0]),
         .word_o(base_sum)
      );
   end

   assign chain[0] = base_sum;

   // fold stages, top address bit first
   for (genvar k = 0; k < LEVELS; k++) begin : g_fold
      localparam int unsigned BIT = TAPS - 1 - k;
      dapsg_fold #(
         .COEF_W(COEF_W),
         .SUM_W (SUM_W),
         .COEF  (COEFS[BIT*COEF_W +: COEF_W])
      ) u_fold (
         .sel_i (tap_bits_i[BIT]),
         .part_i(chain[k]),
         .part_o(chain[k+1])
      );
   end

   assign psum_o = chain[LEVELS];

endmodule

// File: rtl/dapsg_core_chk.sv
module dapsg_core_chk #(
   parameter int unsigned TAPS   = 4,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned LEVELS = 1,
   parameter int unsigned SUM_W  = 14,
   parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
   input logic [TAPS-1:0]         tap_bits_i,
   input logic signed [SUM_W-1:0] psum_o,
   input logic signed [SUM_W-1:0] base_sum
);

   localparam int unsigned TBITS = TAPS - LEVELS;

   function automatic int coef_int(int unsigned i);
      logic signed [COEF_W-1:0] c;
      c = COEFS[i*COEF_W +: COEF_W];
      return int'(c);
   endfunction

   function automatic int subset(logic [TAPS-1:0] a, int unsigned nb);
      int s;
      s = 0;
      for (int unsigned i = 0; i < nb; i++)
         if (a[i]) s += coef_int(i);
      return s;
   endfunction

   function automatic int neg_total();
      int s;
      s = 0;
      for (int unsigned i = 0; i < TAPS; i++)
         if (coef_int(i) < 0) s += coef_int(i);
      return s;
   endfunction

   function automatic int pos_total();
      int s;
      s = 0;
      for (int unsigned i = 0; i < TAPS; i++)
         if (coef_int(i) > 0) s += coef_int(i);
      return s;
   endfunction

   function automatic int onehot_coef(logic [TAPS-1:0] a);
      int r;
      r = 0;
      for (int unsigned i = 0; i < TAPS; i++)
         if (a[i]) r = coef_int(i);
      return r;
   endfunction

   always_comb begin
      // R1: output equals the subset sum over all address bits
      p_subset_match_r1 : assert (int'(psum_o) == subset(tap_bits_i, TAPS))
         else $error("R1 mismatch addr=%b got=%0d", tap_bits_i, psum_o);
      // R2: stored part covers exactly the low TBITS address bits
      p_base_low_r2 : assert (int'(base_sum) == subset(tap_bits_i, TBITS))
         else $error("R2 base mismatch addr=%b got=%0d", tap_bits_i, base_sum);
      // R3: zero address gives zero
      p_zero_addr_r3 : assert (tap_bits_i != '0 || psum_o == '0)
         else $error("R3 nonzero output for zero address");
      // R4: single-bit address gives that coefficient
      p_onehot_r4 : assert (!$onehot(tap_bits_i) || int'(psum_o) == onehot_coef(tap_bits_i))
         else $error("R4 single tap mismatch addr=%b", tap_bits_i);
      // R6: no wrap, output within the signed bounds of the set
      p_no_overflow_r6 : assert (int'(psum_o) >= neg_total() && int'(psum_o) <= pos_total())
         else $error("R6 output out of bounds %0d", psum_o);
   end

endmodule

bind dapsg_core dapsg_core_chk #(
   .TAPS  (TAPS),
   .COEF_W(COEF_W),
   .LEVELS(LEVELS),
   .SUM_W (SUM_W),
   .COEFS (COEFS)
) u_chk (
   .tap_bits_i(tap_bits_i),
   .psum_o    (psum_o),
   .base_sum  (base_sum)
);

// File: tb/dapsg_core_bench.sv
`timescale 1ns/1ps
module dapsg_core_bench;

   localparam int NI = 5;

   // coefficient sets, index = address bit
   localparam int CSET [NI][4] = '{
      '{ -10,   30,  -48,   55},   // inst 0: LEVELS=1
      '{ 362, -321,  247, -158},   // inst 1: LEVELS=0
      '{-2048,-2048,-2048,-2048},  // inst 2: LEVELS=4
      '{2047, 2047, 2047, 2047},   // inst 3: LEVELS=2
      '{ -10,   30,  -48,   55}    // inst 4: LEVELS=3
   };

   typedef struct packed {
      logic [3:0]        a;
      logic [NI-1:0][31:0] e;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic signed [13:0] got [NI];

   item_t q [$];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dapsg_core #(.LEVELS(1), .COEFS({12'sd55, -12'sd48, 12'sd30, -12'sd10}))
      u_dapsg_core (.tap_bits_i(addr), .psum_o(got[0]));
   dapsg_core #(.LEVELS(0), .COEFS({-12'sd158, 12'sd247, -12'sd321, 12'sd362}))
      u_dapsg_core_l0 (.tap_bits_i(addr), .psum_o(got[1]));
   dapsg_core #(.LEVELS(4), .COEFS({-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048}))
      u_dapsg_core_l4 (.tap_bits_i(addr), .psum_o(got[2]));
   dapsg_core #(.LEVELS(2), .COEFS({12'sd2047, 12'sd2047, 12'sd2047, 12'sd2047}))
      u_dapsg_core_l2 (.tap_bits_i(addr), .psum_o(got[3]));
   dapsg_core #(.LEVELS(3), .COEFS({12'sd55, -12'sd48, 12'sd30, -12'sd10}))
      u_dapsg_core_l3 (.tap_bits_i(addr), .psum_o(got[4]));

   function automatic int ref_sum(int inst, logic [3:0] a);
      int s;
      s = 0;
      for (int i = 0; i < 4; i++)
         if (a[i]) s += CSET[inst][i];
      return s;
   endfunction

   function automatic string tag_of(int inst, logic [3:0] a);
      if (a == 4'd0) return "R3";
      if ($onehot(a)) return "R4";
      if (inst == 2 || inst == 3) return "R5/R6";
      if (inst == 0) return "R1";
      return "R2";
   endfunction

   // driver: apply address after the rising edge and queue the expected sums
   task automatic drive(logic [3:0] a);
      item_t it;
      @(posedge clk);
      addr <= a;
      it.a = a;
      for (int k = 0; k < NI; k++) it.e[k] = ref_sum(k, a);
      q.push_back(it);
   endtask

   // monitor: combinational result is due in the same period; compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            for (int k = 0; k < NI; k++) begin
               total++;
               if (int'(got[k]) != $signed(it.e[k])) begin
                  bad++;
                  $display("FAIL %s inst=%0d addr=%b actual=%0d expected=%0d",
                           tag_of(k, it.a), k, it.a, got[k], $signed(it.e[k]));
               end
            end
         end
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      // reset state: address held at zero, every instance gives 0 (R3)
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         total++;
         if (got[k] != 14'sd0) begin
            bad++;
            $display("FAIL R3 reset inst=%0d actual=%0d expected=0", k, got[k]);
         end
      end
      rst_n = 1'b1;
      // ascending sweep of all addresses (R1, R2, R4, R5, R6)
      for (int a = 0; a < 16; a++) drive(4'(a));
      // Gray-code order: one address bit changes per step
      for (int a = 15; a >= 0; a--) drive(4'(a ^ (a >> 1)));
      // top-bit toggling against a fixed low part exercises the folds (R2)
      for (int a = 0; a < 8; a++) begin
         drive(4'(a));
         drive(4'(a | 8));
      end
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      summary();
   end

   initial begin
      #100000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired rst_n=%b actual=hung expected=done", rst_n);
         summary();
      end
   end

endmodule